// File: doc/BRIEF.md
# Breakpoint Debug Mode Controller

This block watches the instruction stream reported by a CPU decoder and decides what happens when a breakpoint instruction (opcode 0x00) shows up. There are three outcomes. If breakpoints are switched off, the instruction does nothing. If breakpoints are on and the loop option is off, the CPU is idled and the controller enters debug mode. If breakpoints are on and the loop option is on, the CPU keeps re-executing the breakpoint. While it does so it can still take interrupts and DMA requests in the background.

The block remembers the address of the breakpoint being looped on, and it reports the looping condition on a status output. Clearing the loop-control bit does not stop the CPU straight away. The halt is deferred until execution comes back to that same breakpoint, so an interrupt routine already running is never cut short. A breakpoint reached at any other address while looping, such as one inside an interrupt routine, stops the CPU at once.

Debug commands are accepted only while the CPU is halted in debug mode. A command issued at any other time is rejected with an error pulse.

Top module: `brk_dbg_ctrl`

## Requirements
- R1: A breakpoint is an instruction with `dec_valid`=1 and `dec_opcode`=8'h00; any other opcode never changes the mode.
- R2: With `brk_en`=0 a breakpoint is ignored: `dbg_mode` and `status_loop` stay 0.
- R3: With `brk_en`=1 and `loop_bit`=0, a breakpoint in run mode raises `dbg_mode` and `cpu_idle` on the next cycle.
- R4: With `brk_en`=1 and `loop_bit`=1, a breakpoint in run mode raises `loop_repeat` combinationally in the same cycle and `status_loop` on the next cycle, while `dbg_mode` and `cpu_idle` stay 0.
- R5: While looping with `loop_bit`=1, a breakpoint at the latched address raises `loop_repeat` and the controller stays in loop mode.
- R6: After `loop_bit` is cleared while looping, other instructions leave loop mode unchanged. The next breakpoint at the latched address sets `dbg_mode` on the following cycle.
- R7: While looping, a breakpoint at any other address sets `dbg_mode` on the next cycle.
- R8: `dbg_exit` returns the controller from debug or loop mode to run mode on the next cycle and has no effect in run mode.
- R9: `cmd_en` is 1 only in debug mode. One cycle after `cmd_valid`, exactly one of `cmd_ok` (issued in debug mode) or `cmd_err` (issued elsewhere) pulses.
- R10: After reset the controller is in run mode and `loop_bit`, `dbg_mode`, `status_loop`, `cpu_idle` and `cmd_en` are 0.
- R11: A `loop_wr` strobe loads `loop_wdata` into `loop_bit`, which is visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoder reports an instruction this cycle |
| dec_opcode | input | 8 | Opcode of the decoded instruction |
| dec_pc | input | ADDR_W | Address of the decoded instruction |
| brk_en | input | 1 | Breakpoints enabled |
| loop_wr | input | 1 | Write strobe for the loop-control bit |
| loop_wdata | input | 1 | Value written to the loop-control bit |
| dbg_exit | input | 1 | Leave debug or loop mode and resume running |
| cmd_valid | input | 1 | A debug command is issued |
| loop_bit | output | 1 | Current loop-control bit |
| status_loop | output | 1 | CPU is looping on a breakpoint |
| dbg_mode | output | 1 | Debug mode active |
| cpu_idle | output | 1 | CPU must stop executing |
| loop_repeat | output | 1 | CPU must re-execute the current breakpoint |
| cmd_en | output | 1 | Debug commands are enabled |
| cmd_ok | output | 1 | The previous command was accepted |
| cmd_err | output | 1 | The previous command was rejected |

## Verification
On every cycle the assertions check that loop and debug modes never overlap. They also check that debug mode is entered only right after an enabled breakpoint, that exit always lands in run mode, that a re-execute request always leaves the block looping, and that each command gets the response matching the enable in force when it was issued. Only the bench scenarios can show the address-dependent behaviour. One case is the deferred halt that waits for a breakpoint at the remembered address after the loop bit is cleared. The other is the immediate stop on a breakpoint elsewhere, since both depend on the address latched on loop entry.

// File: rtl/brk_dbg_pkg.sv
// Package: shared mode encoding for the breakpoint debug controller.
package brk_dbg_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_LOOP = 2'd1,
        MODE_HALT = 2'd2
    } brk_mode_e;
endpackage

// File: rtl/brk_decode_match.sv
// Module: brk_decode_match
// Flags a qualified breakpoint in the decoded instruction stream, and
// whether its address matches the remembered loop address.
// Assumes the decoder holds opcode and address stable while dec_valid is high.
module brk_decode_match #(
    parameter int          ADDR_W     = 16,
    parameter logic [7:0]  BRK_OPCODE = 8'h00
) (
    input  logic              dec_valid,
    input  logic [7:0]        dec_opcode,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic [ADDR_W-1:0] loop_pc,
    input  logic              brk_en,
    output logic              brk_hit,
    output logic              pc_match
);
    // Purpose: qualify the opcode with the enable and compare addresses.
    always_comb begin
        brk_hit  = dec_valid && (dec_opcode == BRK_OPCODE) && brk_en;
        pc_match = (dec_pc == loop_pc);
    end
endmodule

// File: rtl/brk_mode_fsm.sv
// Module: brk_mode_fsm
// Run / loop / halt sequencing. Latches the breakpoint address on loop entry
// and defers the halt until the CPU comes back to that address.
// Assumes brk_hit is already qualified by the breakpoint enable.
module brk_mode_fsm
    import brk_dbg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_hit,
    input  logic              pc_match,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic              loop_bit,
    input  logic              dbg_exit,
    output brk_mode_e         mode,
    output logic [ADDR_W-1:0] loop_pc,
    output logic              loop_repeat
);
    brk_mode_e mode_nx;
    logic      latch_pc;

    // Purpose: next-mode decision and re-execute request.
    always_comb begin
        mode_nx     = mode;
        latch_pc    = 1'b0;
        loop_repeat = 1'b0;
        unique case (mode)
            MODE_RUN: begin
                if (brk_hit) begin
                    if (loop_bit) begin
                        mode_nx     = MODE_LOOP;
                        latch_pc    = 1'b1;
                        loop_repeat = 1'b1;
                    end else begin
                        mode_nx = MODE_HALT;
                    end
                end
            end
            MODE_LOOP: begin
                if (dbg_exit) begin
                    mode_nx = MODE_RUN;
                end else if (brk_hit) begin
                    if (pc_match && loop_bit) begin
                        loop_repeat = 1'b1;
                    end else begin
                        mode_nx = MODE_HALT;
                    end
                end
            end
            MODE_HALT: begin
                if (dbg_exit) begin
                    mode_nx = MODE_RUN;
                end
            end
            default: mode_nx = MODE_RUN;
        endcase
    end

    // Purpose: mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_RUN;
        else        mode <= mode_nx;
    end

    // Purpose: remember the address of the breakpoint being looped on.
    always_ff @(posedge clk) begin
        if (!rst_n)        loop_pc <= '0;
        else if (latch_pc) loop_pc <= dec_pc;
    end
endmodule

// File: rtl/brk_cmd_gate.sv
// Module: brk_cmd_gate
// Enables debug commands only in halt mode and answers every command with
// a one-cycle accept or reject pulse. Assumes one command per cycle at most.
module brk_cmd_gate
    import brk_dbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  brk_mode_e mode,
    input  logic      cmd_valid,
    output logic      cmd_en,
    output logic      cmd_ok,
    output logic      cmd_err
);
    // Purpose: command enable follows halt mode.
    always_comb cmd_en = (mode == MODE_HALT);

    // Purpose: register the accept / reject response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ok  <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            cmd_ok  <= cmd_valid && cmd_en;
            cmd_err <= cmd_valid && !cmd_en;
        end
    end
endmodule

// File: rtl/brk_dbg_ctrl.sv
// Module: brk_dbg_ctrl (top)
// Breakpoint debug mode controller: ignores, halts on, or loops on decoded
// breakpoints, and gates debug commands by mode.
// Assumes the CPU honours cpu_idle and loop_repeat in the cycle they appear.
module brk_dbg_ctrl
    import brk_dbg_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter logic [7:0] BRK_OPCODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [7:0]        dec_opcode,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic              brk_en,
    input  logic              loop_wr,
    input  logic              loop_wdata,
    input  logic              dbg_exit,
    input  logic              cmd_valid,
    output logic              loop_bit,
    output logic              status_loop,
    output logic              dbg_mode,
    output logic              cpu_idle,
    output logic              loop_repeat,
    output logic              cmd_en,
    output logic              cmd_ok,
    output logic              cmd_err
);
    brk_mode_e         mode;
    logic [ADDR_W-1:0] loop_pc;
    logic              brk_hit;
    logic              pc_match;

    // Purpose: loop-control bit, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       loop_bit <= 1'b0;
        else if (loop_wr) loop_bit <= loop_wdata;
    end

    brk_decode_match #(.ADDR_W(ADDR_W), .BRK_OPCODE(BRK_OPCODE)) u_match (
        .dec_valid (dec_valid),
        .dec_opcode(dec_opcode),
        .dec_pc    (dec_pc),
        .loop_pc   (loop_pc),
        .brk_en    (brk_en),
        .brk_hit   (brk_hit),
        .pc_match  (pc_match)
    );

    brk_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_hit    (brk_hit),
        .pc_match   (pc_match),
        .dec_pc     (dec_pc),
        .loop_bit   (loop_bit),
        .dbg_exit   (dbg_exit),
        .mode       (mode),
        .loop_pc    (loop_pc),
        .loop_repeat(loop_repeat)
    );

    brk_cmd_gate u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cmd_valid(cmd_valid),
        .cmd_en   (cmd_en),
        .cmd_ok   (cmd_ok),
        .cmd_err  (cmd_err)
    );

    // Purpose: decode mode into the status outputs.
    always_comb begin
        status_loop = (mode == MODE_LOOP);
        dbg_mode    = (mode == MODE_HALT);
        cpu_idle    = dbg_mode;
    end
endmodule

// File: rtl/brk_dbg_ctrl_checker.sv
// Module: brk_dbg_ctrl_checker
// Port-level properties of the breakpoint debug controller, bound to the top.
module brk_dbg_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_valid,
    input logic [7:0] dec_opcode,
    input logic       brk_en,
    input logic       dbg_exit,
    input logic       cmd_valid,
    input logic       status_loop,
    input logic       dbg_mode,
    input logic       loop_repeat,
    input logic       cmd_en,
    input logic       cmd_ok,
    input logic       cmd_err
);
    assert_modes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_loop && dbg_mode));

    assert_halt_needs_brk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && !(dec_valid && dec_opcode == 8'h00 && brk_en)) |=> !dbg_mode);

    assert_disabled_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && !status_loop && !brk_en) |=> (!dbg_mode && !status_loop));

    assert_repeat_stays_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_repeat |=> status_loop);

    assert_exit_to_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_exit && (dbg_mode || status_loop)) |=> (!dbg_mode && !status_loop));

    assert_cmd_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> ((cmd_ok == $past(cmd_en)) && (cmd_err == !$past(cmd_en))));

    assert_cmd_en_debug_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en == dbg_mode);
endmodule

bind brk_dbg_ctrl brk_dbg_ctrl_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_opcode (dec_opcode),
    .brk_en     (brk_en),
    .dbg_exit   (dbg_exit),
    .cmd_valid  (cmd_valid),
    .status_loop(status_loop),
    .dbg_mode   (dbg_mode),
    .loop_repeat(loop_repeat),
    .cmd_en     (cmd_en),
    .cmd_ok     (cmd_ok),
    .cmd_err    (cmd_err)
);

// File: tb/brk_dbg_ctrl_test.sv
module brk_dbg_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dec_valid = 1'b0;
    logic [7:0]        dec_opcode = 8'hFF;
    logic [ADDR_W-1:0] dec_pc = '0;
    logic              brk_en = 1'b0;
    logic              loop_wr = 1'b0;
    logic              loop_wdata = 1'b0;
    logic              dbg_exit = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              loop_bit, status_loop, dbg_mode, cpu_idle;
    logic              loop_repeat, cmd_en, cmd_ok, cmd_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_dbg_ctrl #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_opcode(dec_opcode),
        .dec_pc(dec_pc), .brk_en(brk_en), .loop_wr(loop_wr), .loop_wdata(loop_wdata),
        .dbg_exit(dbg_exit), .cmd_valid(cmd_valid), .loop_bit(loop_bit),
        .status_loop(status_loop), .dbg_mode(dbg_mode), .cpu_idle(cpu_idle),
        .loop_repeat(loop_repeat), .cmd_en(cmd_en), .cmd_ok(cmd_ok), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // mode summary: 0 run, 1 loop, 2 debug
    function automatic int mode_now();
        return status_loop ? 1 : (dbg_mode ? 2 : 0);
    endfunction

    // One instruction for one cycle; returns loop_repeat seen in that cycle.
    task automatic instr(input logic [7:0] op, input logic [ADDR_W-1:0] pc, output int rep);
        dec_valid = 1'b1; dec_opcode = op; dec_pc = pc;
        #1 rep = int'(loop_repeat);
        @(negedge clk);
        dec_valid = 1'b0; dec_opcode = 8'hFF;
    endtask

    task automatic write_loop(input logic v);
        loop_wr = 1'b1; loop_wdata = v;
        @(negedge clk);
        loop_wr = 1'b0;
    endtask

    task automatic exit_cmd();
        dbg_exit = 1'b1;
        @(negedge clk);
        dbg_exit = 1'b0;
    endtask

    task automatic command(input int exp_ok);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9", "cmd_ok", int'(cmd_ok), exp_ok);
        chk("R9", "cmd_err", int'(cmd_err), 1 - exp_ok);
    endtask

    task automatic t_reset();
        chk("R10", "mode", mode_now(), 0);
        chk("R10", "loop_bit", int'(loop_bit), 0);
        chk("R10", "cpu_idle", int'(cpu_idle), 0);
        chk("R10", "cmd_en", int'(cmd_en), 0);
    endtask

    task automatic t_disabled();
        int rep;
        brk_en = 1'b0;
        instr(8'h00, 16'h0010, rep);
        chk("R2", "mode after disabled brk", mode_now(), 0);
        brk_en = 1'b1;
        instr(8'h01, 16'h0012, rep);
        chk("R1", "mode after non-brk opcode", mode_now(), 0);
        instr(8'h80, 16'h0014, rep);
        chk("R1", "mode after opcode 0x80", mode_now(), 0);
        exit_cmd();
        chk("R8", "exit in run", mode_now(), 0);
        chk("R9", "cmd_en in run", int'(cmd_en), 0);
        command(0);
    endtask

    task automatic t_halt();
        int rep;
        brk_en = 1'b1;
        instr(8'h00, 16'h0020, rep);
        chk("R3", "dbg_mode", int'(dbg_mode), 1);
        chk("R3", "cpu_idle", int'(cpu_idle), 1);
        chk("R3", "repeat on halt", rep, 0);
        chk("R9", "cmd_en in debug", int'(cmd_en), 1);
        command(1);
        exit_cmd();
        chk("R8", "exit from debug", mode_now(), 0);
    endtask

    task automatic t_loop_deferred();
        int rep;
        write_loop(1'b1);
        chk("R11", "loop_bit set", int'(loop_bit), 1);
        instr(8'h00, 16'h0040, rep);
        chk("R4", "repeat on entry", rep, 1);
        chk("R4", "status_loop", int'(status_loop), 1);
        chk("R4", "cpu_idle in loop", int'(cpu_idle), 0);
        command(0);
        instr(8'h00, 16'h0040, rep);
        chk("R5", "repeat at same pc", rep, 1);
        chk("R5", "still looping", mode_now(), 1);
        write_loop(1'b0);
        chk("R11", "loop_bit cleared", int'(loop_bit), 0);
        chk("R6", "loop held after clear", mode_now(), 1);
        instr(8'h3C, 16'h0100, rep);
        instr(8'h12, 16'h0102, rep);
        chk("R6", "isr instrs keep loop", mode_now(), 1);
        instr(8'h00, 16'h0040, rep);
        chk("R6", "no repeat on return", rep, 0);
        chk("R6", "halt on return", mode_now(), 2);
        exit_cmd();
        chk("R8", "exit after deferred halt", mode_now(), 0);
    endtask

    task automatic t_isr_brk();
        int rep;
        write_loop(1'b1);
        instr(8'h00, 16'h0050, rep);
        chk("R4", "loop entered", mode_now(), 1);
        instr(8'h00, 16'h0080, rep);
        chk("R7", "repeat at other pc", rep, 0);
        chk("R7", "halt at other pc", mode_now(), 2);
        exit_cmd();
    endtask

    task automatic t_loop_exit();
        int rep;
        instr(8'h00, 16'h0060, rep);
        chk("R4", "loop again", mode_now(), 1);
        exit_cmd();
        chk("R8", "exit from loop", mode_now(), 0);
        instr(8'h00, 16'h0070, rep);
        chk("R4", "re-enter loop new pc", mode_now(), 1);
        instr(8'h00, 16'h0060, rep);
        chk("R7", "old pc now differs", mode_now(), 2);
        exit_cmd();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_halt();
        t_loop_deferred();
        t_isr_brk();
        t_loop_exit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule